// File: doc/BRIEF.md
# TDM Serial Frame Engine

This block moves audio samples between a parallel word interface and a time-division-multiplexed serial line. A frame is a run of numbered timeslots. Each slot lasts 8, 16 or 32 bit periods, and up to 32 slots make one frame. Transmit words are taken from a FIFO-facing interface at the start of each active slot and shifted out on `sdo`. Bits arriving on `sdi` are gathered into a word and handed to the receive FIFO side at the end of the slot. Sample contents are opaque bits.

The block runs in one of two modes. In master mode it drives its own bit clock at half the system clock rate, and it pulses a frame sync for one bit period during the last bit of each frame. In slave mode it follows an external bit clock and frame sync, both synchronous to `clk`. A 32-bit timing word fixes the mode, the bit order, the slot width and the slot count. A separate mask marks slots that stay silent. A three-bit run word gates the engine as a whole, and gates transmit and receive separately.

Top module: `tdm_frame_engine`

## Requirements
- R1: While reset is asserted, `bclk_o`, `fs_o`, `sdo`, `tx_pop`, `rx_push`, `tx_underrun` and `rx_overrun` are all low.
- R2: `timing_cfg[6:5]` selects the slot length in bit periods: 0 gives 8, 1 gives 16, and 2 or 3 give 32. Only the low W bits of a word are carried.
- R3: `timing_cfg[11:7]` holds the number of slots per frame minus one, so 0 means 1 slot and 31 means 32 slots.
- R4: With `timing_cfg[21]` set (master mode), `bclk_o` toggles on every `clk` cycle while the engine runs, so one bit lasts two cycles. `fs_o` is high for exactly one bit period per frame, during the last bit of the last slot. The first bit of slot 0 follows it.
- R5: With `timing_cfg[21]` clear (slave mode), a bit advances on each rising edge of `bclk_i`. If `fs_i` is high at one of those edges, the next bit is bit 0 of slot 0. Until the first such edge, nothing is transmitted, popped or pushed. `bclk_o` and `fs_o` stay low in this mode.
- R6: `timing_cfg[20]` set sends and assembles each word least significant bit first. Clear means bit W-1 goes first. The received word carries the line bits at the same positions.
- R7: A slot whose bit is set in `slot_mask` (bit s for slot s) drives `sdo` low. It neither pops a transmit word nor pushes a received one.
- R8: `run_ctrl[2]` is the global enable. Without it, `bclk_o`, `fs_o` and `sdo` stay low and no pulses occur. `run_ctrl[0]` enables transmit: when it is clear, `sdo` is low and no word is popped. `run_ctrl[1]` enables receive: when it is clear, no word is pushed.
- R9: If `tx_valid` is low at the first bit of an active transmit slot, the slot sends zeros, `tx_pop` stays low, and `tx_underrun` pulses for one cycle.
- R10: If `rx_full` is high at the last bit of an active receive slot, the word is dropped, `rx_push` stays low, and `rx_overrun` pulses for one cycle.
- R11: Each active transmit slot with data available raises `tx_pop` for one cycle after its first bit is launched. Each active receive slot raises `rx_push` for one cycle with the assembled word on `rx_data`. Words are consumed and produced in slot order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing_cfg | input | 32 | Mode, bit order, slot count and slot width word |
| run_ctrl | input | 3 | Transmit enable, receive enable, global enable |
| slot_mask | input | 32 | Per-slot silence mask |
| bclk_i | input | 1 | External bit clock (slave mode) |
| fs_i | input | 1 | External frame sync (slave mode) |
| sdi | input | 1 | Serial receive data |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| fs_o | output | 1 | Generated frame sync (master mode) |
| sdo | output | 1 | Serial transmit data |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_pop | output | 1 | Take the head transmit word |
| rx_data | output | 32 | Received word |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| tx_underrun | output | 1 | Transmit slot found no data |
| rx_overrun | output | 1 | Received word was dropped |

## Verification
The bench walks a table of slot widths, slot counts, bit orders and masks through complete master frames. These include the reserved width code and a full 32-slot frame. A design that miscounted the width or the N-1 slot field would put the frame sync on the wrong bit. A design with the bit order reversed would return mirrored words. A mask handled only on the transmit side would still push words from silent slots. Directed cases cover a starved transmit FIFO and a full receive FIFO; a design that popped anyway or kept a dropped word would miscount pulses. They also cover each run bit cleared, where a leaking gate shows up as line activity. A slave run with clock pulses but no sync catches a design that moves data before frame lock.

// File: rtl/tdm_frame_engine.sv
module tdm_frame_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] timing_cfg,
  input  logic [2:0]  run_ctrl,
  input  logic [31:0] slot_mask,
  input  logic        bclk_i,
  input  logic        fs_i,
  input  logic        sdi,
  output logic        bclk_o,
  output logic        fs_o,
  output logic        sdo,
  input  logic [31:0] tx_data,
  input  logic        tx_valid,
  output logic        tx_pop,
  output logic [31:0] rx_data,
  output logic        rx_push,
  input  logic        rx_full,
  output logic        tx_underrun,
  output logic        rx_overrun
);
  wire       go       = run_ctrl[2];
  wire       tx_en    = go & run_ctrl[0];
  wire       rx_en    = go & run_ctrl[1];
  wire       master   = timing_cfg[21];
  wire       lsb      = timing_cfg[20];
  wire [4:0] top_slot = timing_cfg[11:7];
  wire       unused_cfg = ^{timing_cfg[31:22], timing_cfg[19:12], timing_cfg[4:0]};

  logic [4:0] top_bit;
  always_comb
    case (timing_cfg[6:5])
      2'd0:    top_bit = 5'd7;
      2'd1:    top_bit = 5'd15;
      default: top_bit = 5'd31;
    endcase

  logic        ph, bclk_q, lock;
  logic [4:0]  slot, bitn;
  logic [31:0] txw, rxw;

  wire        tick    = master ? ph : (bclk_i & ~bclk_q);
  wire        fetch   = (bitn == 5'd0);
  wire        done    = (bitn >= top_bit);
  wire        at_last = (slot >= top_slot) && done;
  wire        mark    = master ? at_last : fs_i;
  wire        live    = lock & ~slot_mask[slot];
  wire [4:0]  idx     = lsb ? bitn : top_bit - bitn;
  wire [31:0] tx_word = fetch ? ((live & tx_en & tx_valid) ? tx_data : '0) : txw;
  wire [31:0] rx_word = (fetch ? 32'd0 : rxw) | (32'(sdi) << idx);

  assign bclk_o = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0; bclk_q <= 1'b0; lock <= 1'b0;
      slot <= '0; bitn <= '0; txw <= '0; rxw <= '0;
      fs_o <= 1'b0; sdo <= 1'b0; rx_data <= '0;
      tx_pop <= 1'b0; rx_push <= 1'b0; tx_underrun <= 1'b0; rx_overrun <= 1'b0;
    end else begin
      tx_pop <= 1'b0; rx_push <= 1'b0; tx_underrun <= 1'b0; rx_overrun <= 1'b0;
      bclk_q <= bclk_i;
      if (!go) begin
        ph <= 1'b0; lock <= 1'b0;
        slot <= top_slot; bitn <= top_bit;
        txw <= '0; rxw <= '0; fs_o <= 1'b0; sdo <= 1'b0;
      end else begin
        ph <= master & ~ph;
        if (!master) fs_o <= 1'b0;
        if (tick) begin
          sdo  <= live & tx_en & tx_word[idx];
          fs_o <= master & at_last;
          txw  <= tx_word;
          rxw  <= rx_word;
          if (fetch && live && tx_en) begin
            if (tx_valid) tx_pop <= 1'b1;
            else          tx_underrun <= 1'b1;
          end
          if (done && live && rx_en) begin
            if (!rx_full) begin
              rx_push <= 1'b1;
              rx_data <= rx_word;
            end else rx_overrun <= 1'b1;
          end
          lock <= lock | mark;
          if (mark) begin
            slot <= '0; bitn <= '0;
          end else if (done) begin
            bitn <= '0;
            slot <= (slot >= top_slot) ? 5'd0 : slot + 5'd1;
          end else bitn <= bitn + 5'd1;
        end
      end
    end
  end
endmodule

module tdm_frame_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] timing_cfg,
  input logic [2:0]  run_ctrl,
  input logic        tx_valid,
  input logic        rx_full,
  input logic        bclk_o,
  input logic        fs_o,
  input logic        tx_pop,
  input logic        tx_underrun,
  input logic        rx_push,
  input logic        rx_overrun
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> !bclk_o && !fs_o && !tx_pop && !rx_push && !tx_underrun && !rx_overrun);

  assert_bclk_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run_ctrl[2]) && $past(timing_cfg[21])) |-> (bclk_o != $past(bclk_o)));

  assert_slave_no_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !timing_cfg[21] |=> !bclk_o && !fs_o);

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ctrl[2] |=> !bclk_o && !fs_o && !tx_pop && !rx_push);

  assert_pop_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> $past(tx_valid) && !tx_underrun);

  assert_push_has_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !$past(rx_full) && !rx_overrun);

  assert_pop_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !tx_pop);

  assert_push_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);
endmodule

bind tdm_frame_engine tdm_frame_engine_chk chk_i (.*);

// File: tb/tdm_frame_engine_tb.sv
module tdm_frame_engine_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [31:0] timing_cfg = 0, slot_mask = 0;
  logic [2:0]  run_ctrl = 0;
  logic bclk_i = 0, fs_i = 0, sdi = 0, rx_full = 0;
  logic bclk_o, fs_o, sdo, tx_pop, rx_push, tx_underrun, rx_overrun;
  logic [31:0] rx_data, tx_data;
  logic [31:0] fifo [32];
  logic [31:0] got [32];
  int rd = 0, wr = 0, nrx = 0, nur = 0, nov = 0;
  int nchk = 0, nfail = 0;
  wire tx_valid = (rd < wr);
  assign tx_data = fifo[rd % 32];

  tdm_frame_engine dut_i (.*);

  // width code, last slot index, lsb-first, mask
  localparam logic [39:0] VEC [6] = '{
    {2'd0, 5'd3,  1'b0, 32'h0000_0000},
    {2'd1, 5'd1,  1'b1, 32'h0000_0000},
    {2'd2, 5'd0,  1'b0, 32'h0000_0000},
    {2'd0, 5'd7,  1'b1, 32'h0000_00A5},
    {2'd3, 5'd2,  1'b0, 32'h0000_0002},
    {2'd0, 5'd31, 1'b0, 32'h8000_0001}
  };

  function automatic logic [31:0] txpat(int k);
    return (32'h9E37_79B9 * (k + 3)) ^ 32'h0000_1234;
  endfunction
  function automatic logic [31:0] rxpat(int k);
    logic [31:0] t = txpat(k + 40);
    return {t[15:0], t[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic mon_neg();
    @(negedge clk);
    if (tx_pop) rd++;
    if (rx_push) begin got[nrx % 32] = rx_data; nrx++; end
    if (tx_underrun) nur++;
    if (rx_overrun) nov++;
  endtask

  task automatic step(bit slave, bit fsv, bit dv, output bit so);
    sdi = dv;
    if (slave) begin
      bclk_i = 1; fs_i = fsv; mon_neg(); so = sdo;
      bclk_i = 0; fs_i = 0; mon_neg();
    end else begin
      mon_neg(); mon_neg(); so = sdo;
    end
  endtask

  task automatic setup(bit slave, logic [1:0] code, logic [4:0] ls, bit lsb, logic [31:0] mask,
                       int base, int nwords, bit full);
    run_ctrl = 0;
    timing_cfg = 32'h0000_0004;
    timing_cfg[21] = !slave; timing_cfg[20] = lsb;
    timing_cfg[11:7] = ls; timing_cfg[6:5] = code;
    slot_mask = mask; rx_full = full; bclk_i = 0; fs_i = 0; sdi = 0;
    repeat (3) mon_neg();
    for (int i = 0; i < 32; i++) fifo[i] = txpat(base + i);
    rd = 0; wr = nwords; nrx = 0; nur = 0; nov = 0;
  endtask

  task automatic run_frame(string tag, bit slave, logic [1:0] code, logic [4:0] ls, bit lsb,
                           logic [31:0] mask, int base, bit tx_on, bit rx_on, bit starve, bit full);
    int w = 8 << ((code > 2) ? 2 : code);
    int n = ls + 1;
    int act = 0, k = 0, fsh = 0, waitc = 0;
    bit so;
    logic [31:0] wm = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    logic [31:0] expw [32];
    for (int s = 0; s < n; s++) if (!mask[s]) act++;
    setup(slave, code, ls, lsb, mask, base, starve ? 0 : act, full);
    run_ctrl = {1'b1, rx_on, tx_on};
    if (slave) step(1, 1, 0, so);
    else begin
      do begin mon_neg(); waitc++; end while (!fs_o && waitc < 100);
      chk("R4", {tag, " first frame sync"}, 32'(fs_o), 32'd1);
    end
    for (int s = 0; s < n; s++) begin
      logic [31:0] seen = 0, ex = 0;
      logic [31:0] rp = rxpat(base + s);
      if (!mask[s]) begin
        if (tx_on && !starve) ex = txpat(base + k) & wm;
        expw[k] = rp & wm;
        k++;
      end
      for (int b = 0; b < w; b++) begin
        int idx = lsb ? b : (w - 1 - b);
        step(slave, 0, rp[idx], so);
        seen[idx] = so;
        if (!slave && fs_o) fsh++;
      end
      chk(mask[s] ? "R7" : "R6", $sformatf("%s slot %0d sdo word", tag, s), seen, ex);
    end
    if (!slave) begin
      chk("R3", {tag, " frame sync count"}, 32'(fsh), 32'd1);
      chk("R2", {tag, " frame sync on last bit"}, 32'(fs_o), 32'd1);
    end
    chk("R11", {tag, " pops"}, 32'(rd), (tx_on && !starve) ? 32'(act) : 32'd0);
    chk("R9", {tag, " underruns"}, 32'(nur), (tx_on && starve) ? 32'(act) : 32'd0);
    chk("R11", {tag, " pushes"}, 32'(nrx), (rx_on && !full) ? 32'(act) : 32'd0);
    chk("R10", {tag, " overruns"}, 32'(nov), (rx_on && full) ? 32'(act) : 32'd0);
    if (rx_on && !full)
      for (int i = 0; i < act; i++)
        chk("R6", $sformatf("%s rx word %0d", tag, i), got[i], expw[i]);
    run_ctrl = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    bit so;
    int ones, highs;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {25'd0, bclk_o, fs_o, sdo, tx_pop, rx_push, tx_underrun, rx_overrun}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++)
      run_frame($sformatf("vec%0d", v), 0, VEC[v][39:38], VEC[v][37:33], VEC[v][32],
                VEC[v][31:0], v * 50, 1, 1, 0, 0);

    run_frame("slave", 1, 2'd1, 5'd2, 1'b1, 32'h2, 400, 1, 1, 0, 0);
    run_frame("tx_off_R8", 0, 2'd0, 5'd1, 1'b0, 32'h0, 500, 0, 1, 0, 0);
    run_frame("rx_off_R8", 0, 2'd0, 5'd1, 1'b0, 32'h0, 520, 1, 0, 0, 0);
    run_frame("underrun", 0, 2'd0, 5'd2, 1'b1, 32'h1, 540, 1, 1, 1, 0);
    run_frame("overrun", 0, 2'd1, 5'd1, 1'b0, 32'h0, 560, 1, 1, 0, 1);

    setup(1, 2'd0, 5'd1, 1'b0, 32'h0, 600, 4, 0);
    run_ctrl = 3'b111;
    ones = 0;
    for (int i = 0; i < 24; i++) begin step(1, 0, 1, so); ones += so; end
    chk("R5", "sdo ones before sync", 32'(ones), 32'd0);
    chk("R5", "pops before sync", 32'(rd), 32'd0);
    chk("R5", "pushes before sync", 32'(nrx), 32'd0);

    setup(0, 2'd0, 5'd1, 1'b0, 32'h0, 700, 4, 0);
    run_ctrl = 3'b011;
    highs = 0;
    for (int i = 0; i < 40; i++) begin mon_neg(); highs += (bclk_o | fs_o | sdo); end
    chk("R8", "line activity without global enable", 32'(highs), 32'd0);
    chk("R8", "pops without global enable", 32'(rd), 32'd0);
    run_ctrl = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule